// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block holds the program counter of a 32-bit RISC core and works out, for every instruction, where execution goes next. Each cycle it takes the instruction word fetched at the current PC and the value of the Ra source register. It first forms the updated PC, which is PC+4 with the supervisor flag in bit 31 left untouched. The block then chooses between the updated PC, a PC-relative branch target and a register-indirect jump target. The chosen value is loaded into the PC register on the next rising clock edge.

The two conditional branches (equal-to-zero and not-equal-to-zero) and the register jump always hand back the updated PC as a link value, whether or not control transfers. A link write-enable accompanies it, so the register file can store it in Rc. Bit 31 of the PC marks supervisor mode. Branches carry it over unchanged. A jump can only clear it, never set it. Every other opcode simply advances by four and requests no link write.

The register file is expected to supply zero for Ra when Ra names register 31. This makes an equal-to-zero branch on that register unconditional.

Top module: `npc_unit`

## Requirements
- R1: While rst_n is low at a rising edge, the PC register is loaded with 0x80000000, which is supervisor mode at address zero.
- R2: For any opcode (instruction bits 31:26) other than 0x1C, 0x1D and 0x1B, next_pc_o is the updated PC and link_we_o is 0. The updated PC is bit 31 of the PC followed by PC bits 30:0 plus 4, taken modulo 2^31.
- R3: For opcode 0x1C, next_pc_o is the branch target when ra_val_i is zero, and the updated PC otherwise.
- R4: For opcode 0x1D, next_pc_o is the branch target when ra_val_i is nonzero, and the updated PC otherwise.
- R5: The branch target has bit 31 equal to the current PC bit 31. Its bits 30:0 are the low 31 bits of the updated PC plus 4 times the sign-extended literal in instruction bits 15:0.
- R6: For opcode 0x1B, next_pc_o bits 30:2 equal ra_val_i bits 30:2, and bits 1:0 are zero.
- R7: For opcodes 0x1C, 0x1D and 0x1B, link_o equals the updated PC, whether or not the transfer is taken. link_we_o is 1 unless R8 applies.
- R8: When the Rc field (instruction bits 25:21) is 31, link_we_o is 0 for every opcode.
- R9: Out of reset, pc_o after each rising edge equals the next_pc_o presented before that edge.
- R10: Bits 1:0 of pc_o and of next_pc_o are always zero.
- R11: For opcode 0x1B, next_pc_o bit 31 is the current PC bit 31 ANDed with ra_val_i bit 31. As a result, no instruction can move the PC from user mode (bit 31 = 0) into supervisor mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word fetched at pc_o |
| ra_val_i | input | 32 | Value of source register Ra (zero for register 31) |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | PC to be loaded at the next edge |
| link_o | output | 32 | Updated PC to write into Rc |
| link_we_o | output | 1 | Link write request for Rc |

## Verification
The assertions check several behaviours on every cycle. These are the reset value and the PC tracking next_pc_o, word alignment, and the one-way supervisor flag. They also cover the jump target bits, fall-through of an untaken branch to the link value, and the absence of link writes for sequential opcodes or for Rc = 31. The full arithmetic of the branch target cannot be seen by a property that does not repeat the adder. The same holds for the wrap of the 31-bit address field and for the exact link value. Those are shown by the bench's scenarios, which use a directed sweep of taken and untaken branches, negative offsets, supervisor-clearing jumps and address wrap. Seeded random instruction streams compared against a bench reference model complete the picture.

// File: rtl/npc_pkg.sv
// npc_pkg: shared constants and types for the next-PC unit.
// Assumes a 32-bit instruction word with the opcode in bits 31:26.
package npc_pkg;
    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int LIT_W   = 16;

    localparam logic [OPC_W-1:0] OPC_BR_ZERO    = 6'h1C;
    localparam logic [OPC_W-1:0] OPC_BR_NONZERO = 6'h1D;
    localparam logic [OPC_W-1:0] OPC_JUMP_REG   = 6'h1B;
    localparam logic [REG_W-1:0] REG_ALWAYS_ZERO = 5'd31;

    typedef enum logic [1:0] {
        FLOW_SEQ  = 2'd0,
        FLOW_BRZ  = 2'd1,
        FLOW_BRNZ = 2'd2,
        FLOW_JUMP = 2'd3
    } flow_kind_e;
endpackage

// File: rtl/npc_decode.sv
// npc_decode: classifies the opcode into a control-flow kind and decides
// whether a link write is requested. Assumes Rc = 31 discards writes.
module npc_decode
    import npc_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    input  logic [REG_W-1:0] rc_i,
    output flow_kind_e       kind_o,
    output logic             link_req_o
);
    // Map opcode to flow kind; all other opcodes are sequential.
    always_comb begin
        unique case (opc_i)
            OPC_BR_ZERO:    kind_o = FLOW_BRZ;
            OPC_BR_NONZERO: kind_o = FLOW_BRNZ;
            OPC_JUMP_REG:   kind_o = FLOW_JUMP;
            default:        kind_o = FLOW_SEQ;
        endcase
    end

    // Control-flow ops link unless the destination is the zero register.
    always_comb begin
        link_req_o = (kind_o != FLOW_SEQ) && (rc_i != REG_ALWAYS_ZERO);
    end
endmodule

// File: rtl/npc_target.sv
// npc_target: forms the updated PC, the PC-relative branch target and the
// register jump target. Bit XLEN-1 is the supervisor flag: it is kept by
// sequential flow and branches, and can only be cleared by a jump.
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [LIT_W-1:0] lit_i,
    input  logic [XLEN-1:0]  ra_i,
    output logic [XLEN-1:0]  plus4_o,
    output logic [XLEN-1:0]  br_tgt_o,
    output logic [XLEN-1:0]  jmp_tgt_o
);
    localparam int ADDR_W = XLEN - 1;
    localparam int EXT_W  = XLEN - LIT_W - 2;

    logic [XLEN-1:0] byte_off;
    logic            sup;

    // Supervisor flag of the current PC.
    assign sup = pc_i[XLEN-1];

    // Word offset scaled to bytes with sign extension.
    always_comb begin
        byte_off = {{EXT_W{lit_i[LIT_W-1]}}, lit_i, 2'b00};
    end

    // Updated PC: address field advances by four, flag kept.
    always_comb begin
        plus4_o = {sup, pc_i[ADDR_W-1:0] + ADDR_W'(4)};
    end

    // Branch target: offset added to updated PC address field, flag kept.
    always_comb begin
        br_tgt_o = {sup, plus4_o[ADDR_W-1:0] + byte_off[ADDR_W-1:0]};
    end

    // Jump target: aligned Ra, flag can only be cleared.
    always_comb begin
        jmp_tgt_o = {sup & ra_i[XLEN-1], ra_i[ADDR_W-1:2], 2'b00};
    end
endmodule

// File: rtl/npc_pc_reg.sv
// npc_pc_reg: the program counter register with synchronous active-low reset.
// Assumes the next value is always word aligned.
module npc_pc_reg #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'h8000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pc_d,
    output logic [XLEN-1:0] pc_q
);
    // Load reset value or the selected next PC every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/npc_unit.sv
// npc_unit: next-PC and branch unit. Selects sequential, conditional branch
// or register jump flow for the instruction at pc_o, and produces the link
// value with its write request. Assumes ra_val_i is zero when Ra is R31 and
// that instr_i is valid every cycle.
module npc_unit
    import npc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'h8000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] ra_val_i,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] next_pc_o,
    output logic [XLEN-1:0] link_o,
    output logic            link_we_o
);
    flow_kind_e      kind;
    logic            link_req;
    logic [XLEN-1:0] plus4;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jmp_tgt;
    logic            ra_is_zero;

    npc_decode u_decode (
        .opc_i      (instr_i[31:26]),
        .rc_i       (instr_i[25:21]),
        .kind_o     (kind),
        .link_req_o (link_req)
    );

    npc_target #(.XLEN(XLEN)) u_target (
        .pc_i      (pc_o),
        .lit_i     (instr_i[LIT_W-1:0]),
        .ra_i      (ra_val_i),
        .plus4_o   (plus4),
        .br_tgt_o  (br_tgt),
        .jmp_tgt_o (jmp_tgt)
    );

    // Zero test of Ra for the two conditional branches.
    assign ra_is_zero = (ra_val_i == '0);

    // Pick the next PC according to the flow kind and condition.
    always_comb begin
        unique case (kind)
            FLOW_BRZ:  next_pc_o = ra_is_zero  ? br_tgt : plus4;
            FLOW_BRNZ: next_pc_o = !ra_is_zero ? br_tgt : plus4;
            FLOW_JUMP: next_pc_o = jmp_tgt;
            default:   next_pc_o = plus4;
        endcase
    end

    // Link value is always the updated PC; write only when requested.
    assign link_o    = plus4;
    assign link_we_o = link_req;

    npc_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .pc_d  (next_pc_o),
        .pc_q  (pc_o)
    );
endmodule

// File: rtl/npc_unit_chk.sv
// npc_unit_chk: cycle-by-cycle properties of the next-PC unit, bound to it.
module npc_unit_chk
    import npc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'h8000_0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OPC_W-1:0] opc,
    input logic [REG_W-1:0] rc,
    input logic [XLEN-1:0]  ra_val,
    input logic [XLEN-1:0]  pc,
    input logic [XLEN-1:0]  next_pc,
    input logic [XLEN-1:0]  link,
    input logic             link_we
);
    logic is_ctrl;
    assign is_ctrl = (opc == OPC_BR_ZERO) || (opc == OPC_BR_NONZERO) || (opc == OPC_JUMP_REG);

    AST_RESET_PC: assert property (@(posedge clk)
        !rst_n |=> pc == RESET_PC); // R1

    AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pc == $past(next_pc)); // R9

    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00 && next_pc[1:0] == 2'b00); // R10

    AST_NO_SUP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !pc[XLEN-1] |-> !next_pc[XLEN-1]); // R11

    AST_UNTAKEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ((opc == OPC_BR_ZERO && ra_val != '0) || (opc == OPC_BR_NONZERO && ra_val == '0))
        |-> next_pc == link); // R4

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        opc == OPC_JUMP_REG |-> next_pc[XLEN-2:2] == ra_val[XLEN-2:2]); // R6

    AST_ZERO_REG_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        rc == REG_ALWAYS_ZERO |-> !link_we); // R8

    AST_SEQ_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        !is_ctrl |-> !link_we); // R2
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .opc     (instr_i[31:26]),
    .rc      (instr_i[25:21]),
    .ra_val  (ra_val_i),
    .pc      (pc_o),
    .next_pc (next_pc_o),
    .link    (link_o),
    .link_we (link_we_o)
);

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] ra_val = 32'h0;
    logic [31:0] pc_o, next_pc_o, link_o;
    logic        link_we_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_pc;
    bit done = 0;

    always #2.5 clk = ~clk;

    npc_unit u_npc_unit (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .ra_val_i(ra_val),
        .pc_o(pc_o), .next_pc_o(next_pc_o), .link_o(link_o), .link_we_o(link_we_o)
    );

    function automatic logic [31:0] f_plus4(input logic [31:0] pc);
        return {pc[31], pc[30:0] + 31'd4};
    endfunction

    function automatic logic [31:0] f_next(input logic [31:0] pc, input logic [31:0] ins,
                                           input logic [31:0] ra);
        logic [31:0] p4, off, br;
        p4  = f_plus4(pc);
        off = {{14{ins[15]}}, ins[15:0], 2'b00};
        br  = {pc[31], p4[30:0] + off[30:0]};
        case (ins[31:26])
            6'h1C:   return (ra == 0) ? br : p4;
            6'h1D:   return (ra != 0) ? br : p4;
            6'h1B:   return {pc[31] & ra[31], ra[30:2], 2'b00};
            default: return p4;
        endcase
    endfunction

    function automatic bit f_ctrl(input logic [31:0] ins);
        return ins[31:26] == 6'h1C || ins[31:26] == 6'h1D || ins[31:26] == 6'h1B;
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rc,
                                       input logic [4:0] ra, input logic [15:0] lit);
        return {opc, rc, ra, lit};
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One instruction: check combinational outputs, then the PC after the edge.
    task automatic step(input logic [31:0] ins, input logic [31:0] ra, input string req);
        logic [31:0] exp;
        instr = ins; ra_val = ra;
        #1;
        exp = f_next(m_pc, ins, ra);
        check(next_pc_o, exp, req);
        if (f_ctrl(ins)) begin
            check(link_o, f_plus4(m_pc), "R7 link value");
            check({31'd0, link_we_o}, {31'd0, ins[25:21] != 5'd31}, "R7/R8 link enable");
        end else begin
            check({31'd0, link_we_o}, 32'd0, "R2 no link");
        end
        check({30'd0, next_pc_o[1:0]}, 32'd0, "R10 alignment");
        if (!m_pc[31]) check({31'd0, next_pc_o[31]}, 32'd0, "R11 flag not set");
        @(posedge clk); #1;
        check(pc_o, exp, "R9 pc load");
        m_pc = exp;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); #1;
        check(pc_o, 32'h8000_0000, "R1 reset pc");
        @(negedge clk);
        rst_n = 1'b1;
        m_pc = 32'h8000_0000;
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] ins, ra;
            int sel;
            sel = $urandom_range(0, 5);
            ins = $urandom;
            case (sel)
                0: ins[31:26] = 6'h1C;
                1: ins[31:26] = 6'h1D;
                2: ins[31:26] = 6'h1B;
                default: ;
            endcase
            ra = ($urandom_range(0, 2) == 0) ? 32'h0 : $urandom;
            step(ins, ra, sel == 0 ? "R3 random" : sel == 1 ? "R4 random" :
                          sel == 2 ? "R6 random" : "R2 random");
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        step(mk(6'h20, 5'd1, 5'd2, 16'h0000), 32'h1234, "R2 add advances");
        step(mk(6'h1C, 5'd2, 5'd31, 16'd3), 32'h0, "R3 R5 beq taken on zero reg");
        step(mk(6'h1C, 5'd2, 5'd4, 16'd3), 32'h5, "R3 beq not taken");
        step(mk(6'h1D, 5'd3, 5'd4, 16'hFFFE), 32'h7, "R4 R5 bne taken negative offset");
        step(mk(6'h1D, 5'd3, 5'd4, 16'h0010), 32'h0, "R4 bne not taken");
        step(mk(6'h1C, 5'd31, 5'd31, 16'h0001), 32'h0, "R8 link to zero reg");
        step(mk(6'h1B, 5'd5, 5'd6, 16'h0000), 32'h8000_1237, "R6 jump keeps supervisor");
        step(mk(6'h1B, 5'd5, 5'd5, 16'h0000), 32'h0000_0100, "R11 jump clears supervisor");
        step(mk(6'h1B, 5'd5, 5'd6, 16'h0000), 32'hFFFF_FFF0, "R11 jump cannot set supervisor");
        step(mk(6'h1B, 5'd0, 5'd6, 16'h0000), 32'h7FFF_FFFC, "R6 jump to top of user space");
        step(mk(6'h30, 5'd1, 5'd2, 16'h0004), 32'h0, "R2 address wrap stays user");
        step(mk(6'h1D, 5'd1, 5'd2, 16'h8000), 32'h1, "R5 most negative offset wraps");
        random_run(300);
        do_reset();
        step(mk(6'h1C, 5'd1, 5'd31, 16'hFFFF), 32'h0, "R3 R5 branch to self");
        random_run(300);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule